// File: doc/BRIEF.md
# Program Memory Table Read Unit

This block lets a processor core read a word of program ROM as data. It has an 8-bit table pointer register and a read-only high-byte register, both placed at fixed addresses in the data register space. When the core issues a table read, the block builds a 12-bit ROM address. The low 8 bits always come from the table pointer. The top 4 bits come from one of two places: the page of the current program counter, or the last ROM page, where all four bits are ones. One page holds 256 words.

A table read takes two cycles. In the first cycle the block presents the address to a synchronous ROM. In the second cycle the fetched word comes back. The low byte of that word goes out on a data-memory write port, addressed by the instruction's operand. The upper 6 bits of the 14-bit word are loaded into the low part of the high-byte register, and the register's top two bits read as zero. Instruction decode sits outside the block. The core supplies a start pulse, the page mode, the destination address and the program counter.

Top module: `tblrd_unit`

## Requirements
- R1: After reset, busy_o, rom_en_o and dm_we_o are 0, and reading address 07H or 08H returns 0.
- R2: When page mode is current (mode_i=0), rom_addr_o in the cycle after an accepted start equals {pc_i[11:8], pointer}, and rom_en_o is 1 in that cycle. pc_i and the pointer are sampled at the accepting edge.
- R3: When page mode is last (mode_i=1), rom_addr_o in the cycle after an accepted start equals {4'hF, pointer}.
- R4: busy_o is 1 for exactly the two cycles after an accepted start. rom_en_o is 1 only in the first of those cycles, and dm_we_o is 1 only in the second.
- R5: In the second cycle, dm_addr_o equals the operand dst_i captured at start, and dm_data_o equals bits 7:0 of the ROM word.
- R6: After a table read completes, reading address 08H returns {2'b00, word[13:8]}.
- R7: A core write (wr_en_i=1) to address 07H sets the pointer, and reading 07H on rd_data_o returns it.
- R8: A core write to address 08H has no effect on the high-byte register.
- R9: A start that arrives while busy_o is 1 is ignored. No third busy cycle and no extra ROM access follow.
- R10: A pointer write made during a table read does not change the address of the fetch in progress. The new pointer value reads back afterwards.
- R11: When the operand is 07H, the completing read loads the low byte into the pointer. This takes priority over a core write to 07H in the same cycle.
- R12: Reading any address other than 07H or 08H returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Table-read request pulse |
| mode_i | input | 1 | Page mode: 0 = current PC page, 1 = last page |
| dst_i | input | 8 | Data-memory destination for the low byte |
| pc_i | input | 12 | Current program counter |
| rom_en_o | output | 1 | ROM read enable |
| rom_addr_o | output | 12 | ROM read address |
| rom_data_i | input | 14 | ROM word, valid the cycle after enable |
| wr_en_i | input | 1 | Core register write strobe |
| wr_addr_i | input | 8 | Core register write address |
| wr_data_i | input | 8 | Core register write data |
| rd_addr_i | input | 8 | Core register read address |
| rd_data_o | output | 8 | Core register read data (combinational) |
| dm_we_o | output | 1 | Data-memory write enable for the low byte |
| dm_addr_o | output | 8 | Data-memory write address |
| dm_data_o | output | 8 | Data-memory write data |
| busy_o | output | 1 | Table read in progress |

## Verification
If the sequencer state is wrong, it shows up on busy_o, rom_en_o or dm_we_o in the cycle right after the start. A sequencer that gets stuck shows as busy_o staying high past the second cycle. If the captured address or operand is wrong, the mismatch appears on rom_addr_o in the first cycle and on dm_addr_o in the second. If the high-byte or pointer register is corrupted, the error does not appear at any output until the core reads 08H or 07H. For that reason the bench reads both registers back right after each completion and after each ignored write.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;

    typedef enum logic [1:0] {
        TR_IDLE  = 2'd0,
        TR_FETCH = 2'd1,
        TR_LOAD  = 2'd2
    } tr_state_e;

    typedef enum logic {
        PG_CURRENT = 1'b0,
        PG_LAST    = 1'b1
    } pg_mode_e;

endpackage

// File: rtl/tblrd_addr_mux.sv
module tblrd_addr_mux #(
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 8
) (
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [PTR_W-1:0]  ptr_i,
    output logic [ADDR_W-1:0] addr_o
);
    import tblrd_pkg::*;

    localparam int PAGE_W = ADDR_W - PTR_W;

    logic [PAGE_W-1:0] page_sel;

    // Each page bit is either a forced one or the matching PC bit
    for (genvar g = 0; g < PAGE_W; g++) begin : g_page
        always_comb begin
            if (pg_mode_e'(mode_i) == PG_LAST) begin
                page_sel[g] = 1'b1;
            end else begin
                page_sel[g] = pc_i[PTR_W + g];
            end
        end
    end

    assign addr_o = {page_sel, ptr_i};

endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq #(
    parameter int ADDR_W  = 12,
    parameter int DADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DADDR_W-1:0] dst_i,
    output logic               busy_o,
    output logic               rom_en_o,
    output logic [ADDR_W-1:0]  rom_addr_o,
    output logic               done_o,
    output logic [DADDR_W-1:0] dst_o
);
    import tblrd_pkg::*;

    typedef struct packed {
        tr_state_e          state;
        logic [ADDR_W-1:0]  addr;
        logic [DADDR_W-1:0] dst;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            TR_IDLE: begin
                if (start_i) begin
                    s_d.state = TR_FETCH;
                    s_d.addr  = addr_i;
                    s_d.dst   = dst_i;
                end
            end
            TR_FETCH: s_d.state = TR_LOAD;
            TR_LOAD:  s_d.state = TR_IDLE;
            default:  s_d.state = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: TR_IDLE, addr: '0, dst: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = (s_q.state != TR_IDLE);
    assign rom_en_o   = (s_q.state == TR_FETCH);
    assign rom_addr_o = s_q.addr;
    assign done_o     = (s_q.state == TR_LOAD);
    assign dst_o      = s_q.dst;

endmodule

// File: rtl/tblrd_regs.sv
module tblrd_regs #(
    parameter int WORD_W   = 14,
    parameter int DATA_W   = 8,
    parameter int DADDR_W  = 8,
    parameter int PTR_ADDR = 7,
    parameter int HI_ADDR  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [DADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [DADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic               done_i,
    input  logic [DADDR_W-1:0] dst_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic [DATA_W-1:0]  ptr_o,
    output logic [DATA_W-1:0]  hi_o
);
    localparam int HI_W = WORD_W - DATA_W;
    localparam logic [DADDR_W-1:0] PTR_A = DADDR_W'(PTR_ADDR);
    localparam logic [DADDR_W-1:0] HI_A  = DADDR_W'(HI_ADDR);

    typedef struct packed {
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] hi;
    } regs_t;

    regs_t r_d, r_q;
    logic [DATA_W-1:0] hi_fill;

    // Upper word bits fill the high register from bit 0, the rest is zero
    if (HI_W < DATA_W) begin : g_pad
        assign hi_fill = {{(DATA_W - HI_W){1'b0}}, word_i[WORD_W-1:DATA_W]};
    end else begin : g_full
        assign hi_fill = word_i[DATA_W +: DATA_W];
    end

    always_comb begin
        r_d = r_q;
        if (wr_en_i && wr_addr_i == PTR_A) begin
            r_d.ptr = wr_data_i;
        end
        // a write to the high register address changes nothing
        if (done_i) begin
            r_d.hi = hi_fill;
            if (dst_i == PTR_A) begin
                r_d.ptr = word_i[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (rd_addr_i == PTR_A) begin
            rd_data_o = r_q.ptr;
        end else if (rd_addr_i == HI_A) begin
            rd_data_o = r_q.hi;
        end else begin
            rd_data_o = '0;
        end
    end

    assign ptr_o = r_q.ptr;
    assign hi_o  = r_q.hi;

endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
    parameter int ADDR_W   = 12,
    parameter int WORD_W   = 14,
    parameter int DATA_W   = 8,
    parameter int DADDR_W  = 8,
    parameter int PTR_ADDR = 7,
    parameter int HI_ADDR  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [DADDR_W-1:0] dst_i,
    input  logic [ADDR_W-1:0]  pc_i,
    output logic               rom_en_o,
    output logic [ADDR_W-1:0]  rom_addr_o,
    input  logic [WORD_W-1:0]  rom_data_i,
    input  logic               wr_en_i,
    input  logic [DADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [DADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               dm_we_o,
    output logic [DADDR_W-1:0] dm_addr_o,
    output logic [DATA_W-1:0]  dm_data_o,
    output logic               busy_o
);
    logic [DATA_W-1:0]  ptr_w;
    logic [DATA_W-1:0]  hi_w;
    logic [ADDR_W-1:0]  mux_addr;
    logic               done_w;
    logic [DADDR_W-1:0] dst_w;

    tblrd_addr_mux #(.ADDR_W(ADDR_W), .PTR_W(DATA_W)) i_mux (
        .mode_i (mode_i),
        .pc_i   (pc_i),
        .ptr_i  (ptr_w),
        .addr_o (mux_addr)
    );

    tblrd_seq #(.ADDR_W(ADDR_W), .DADDR_W(DADDR_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (mux_addr),
        .dst_i      (dst_i),
        .busy_o     (busy_o),
        .rom_en_o   (rom_en_o),
        .rom_addr_o (rom_addr_o),
        .done_o     (done_w),
        .dst_o      (dst_w)
    );

    tblrd_regs #(
        .WORD_W(WORD_W), .DATA_W(DATA_W), .DADDR_W(DADDR_W),
        .PTR_ADDR(PTR_ADDR), .HI_ADDR(HI_ADDR)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .done_i    (done_w),
        .dst_i     (dst_w),
        .word_i    (rom_data_i),
        .ptr_o     (ptr_w),
        .hi_o      (hi_w)
    );

    assign dm_we_o   = done_w;
    assign dm_addr_o = dst_w;
    assign dm_data_o = rom_data_i[DATA_W-1:0];

endmodule

// File: rtl/tblrd_chk.sv
module tblrd_chk #(
    parameter int ADDR_W   = 12,
    parameter int WORD_W   = 14,
    parameter int DATA_W   = 8,
    parameter int DADDR_W  = 8,
    parameter int HI_ADDR  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               mode_i,
    input logic [ADDR_W-1:0]  pc_i,
    input logic               rom_en_o,
    input logic [ADDR_W-1:0]  rom_addr_o,
    input logic [WORD_W-1:0]  rom_data_i,
    input logic               wr_en_i,
    input logic [DADDR_W-1:0] wr_addr_i,
    input logic               dm_we_o,
    input logic               busy_o,
    input logic [DATA_W-1:0]  ptr_w,
    input logic [DATA_W-1:0]  hi_w
);
    localparam int HI_W = WORD_W - DATA_W;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rom_en_o && !dm_we_o));

    // R4
    fetch_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en_o |=> (dm_we_o && busy_o && !rom_en_o));

    // R4
    load_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |=> !busy_o);

    // R9
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> rom_en_o);

    // R2
    cur_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en_o && !$past(mode_i)) |->
            (rom_addr_o == {$past(pc_i[ADDR_W-1:DATA_W]), $past(ptr_w)}));

    // R3
    last_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en_o && $past(mode_i)) |->
            (rom_addr_o == {{(ADDR_W-DATA_W){1'b1}}, $past(ptr_w)}));

    // R6
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we_o |=> ((hi_w >> HI_W) == '0 &&
                     hi_w[HI_W-1:0] == $past(rom_data_i[WORD_W-1:DATA_W])));

    // R8
    hi_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == DADDR_W'(HI_ADDR) && !dm_we_o) |=> $stable(hi_w));

endmodule

bind tblrd_unit tblrd_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
    .DADDR_W(DADDR_W), .HI_ADDR(HI_ADDR)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .pc_i       (pc_i),
    .rom_en_o   (rom_en_o),
    .rom_addr_o (rom_addr_o),
    .rom_data_i (rom_data_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .dm_we_o    (dm_we_o),
    .busy_o     (busy_o),
    .ptr_w      (ptr_w),
    .hi_w       (hi_w)
);

// File: tb/test_tblrd_unit.sv
module test_tblrd_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [7:0]  dst_i = '0;
    logic [11:0] pc_i = '0;
    logic        rom_en_o;
    logic [11:0] rom_addr_o;
    logic [13:0] rom_data_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [7:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        dm_we_o;
    logic [7:0]  dm_addr_o;
    logic [7:0]  dm_data_o;
    logic        busy_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tblrd_unit i_tblrd_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .dst_i(dst_i), .pc_i(pc_i), .rom_en_o(rom_en_o), .rom_addr_o(rom_addr_o),
        .rom_data_i(rom_data_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_data_o(dm_data_o),
        .busy_o(busy_o)
    );

    function automatic logic [13:0] rom_fn(input logic [11:0] a);
        return 14'((a * 14'd37) ^ 14'h2A5B ^ {a[3:0], 10'h0});
    endfunction

    // synchronous ROM model
    always @(posedge clk) if (rom_en_o) rom_data_i <= rom_fn(rom_addr_o);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        rd_addr_i = a;
        #1;
        chk(rd_data_o == exp, tag, rd_data_o, exp);
    endtask

    // {mode, page, ptr, dst}
    localparam logic [20:0] VEC [0:5] = '{
        {1'b0, 4'h3, 8'h5A, 8'h20},
        {1'b1, 4'h3, 8'h5A, 8'h21},
        {1'b0, 4'h0, 8'h00, 8'h30},
        {1'b0, 4'hF, 8'hFF, 8'h31},
        {1'b1, 4'h0, 8'h01, 8'h40},
        {1'b0, 4'hA, 8'hC3, 8'h08}
    };

    task automatic run_read(input bit m, input logic [3:0] pg, input logic [7:0] p,
                            input logic [7:0] d);
        logic [11:0] ea;
        logic [13:0] w;
        ea = {(m ? 4'hF : pg), p};
        w  = rom_fn(ea);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 8'h07; wr_data_i = p;
        @(negedge clk);
        wr_en_i = 1'b0; start_i = 1'b1; mode_i = m; pc_i = {pg, 8'h33}; dst_i = d;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && rom_en_o && !dm_we_o, "R4 cycle1", {busy_o, rom_en_o, dm_we_o}, 3'b110);
        chk(rom_addr_o == ea, m ? "R3 last page addr" : "R2 current page addr", rom_addr_o, ea);
        @(negedge clk);
        chk(busy_o && !rom_en_o && dm_we_o, "R4 cycle2", {busy_o, rom_en_o, dm_we_o}, 3'b101);
        chk(dm_addr_o == d && dm_data_o == w[7:0], "R5 low byte",
            {dm_addr_o, dm_data_o}, {d, w[7:0]});
        @(negedge clk);
        chk(!busy_o && !dm_we_o, "R4 done", {busy_o, dm_we_o}, 0);
        rd_chk(8'h08, {2'b00, w[13:8]}, "R6 high reg");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [13:0] w;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !rom_en_o && !dm_we_o, "R1 outputs", {busy_o, rom_en_o, dm_we_o}, 0);
        rd_chk(8'h07, 8'h00, "R1 ptr");
        rd_chk(8'h08, 8'h00, "R1 hi");
        rst_n = 1'b1;

        foreach (VEC[i]) run_read(VEC[i][20], VEC[i][19:16], VEC[i][15:8], VEC[i][7:0]);

        // R7 pointer write and read back
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 8'h07; wr_data_i = 8'h9C;
        @(negedge clk);
        wr_en_i = 1'b0;
        rd_chk(8'h07, 8'h9C, "R7 ptr readback");

        // R8 write to high register ignored
        w = rom_fn({4'hA, 8'hC3});
        wr_en_i = 1'b1; wr_addr_i = 8'h08; wr_data_i = 8'hFF;
        @(negedge clk);
        wr_en_i = 1'b0;
        rd_chk(8'h08, {2'b00, w[13:8]}, "R8 hi unchanged");

        // R12 other addresses read zero
        rd_chk(8'h10, 8'h00, "R12 other addr");
        rd_chk(8'h06, 8'h00, "R12 addr 06");

        // R9 start while busy ignored, R10 pointer write during fetch
        start_i = 1'b1; mode_i = 1'b0; pc_i = 12'h533; dst_i = 8'h50;
        @(negedge clk);
        mode_i = 1'b1; // still requesting
        wr_en_i = 1'b1; wr_addr_i = 8'h07; wr_data_i = 8'h11;
        chk(rom_addr_o == 12'h59C, "R10 addr uses old ptr", rom_addr_o, 12'h59C);
        @(negedge clk);
        wr_en_i = 1'b0;
        w = rom_fn(12'h59C);
        chk(dm_data_o == w[7:0], "R10 data from old addr", dm_data_o, w[7:0]);
        start_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && !rom_en_o, "R9 no extra read", {busy_o, rom_en_o}, 0);
        rd_chk(8'h07, 8'h11, "R10 new ptr");
        @(negedge clk);
        chk(!busy_o, "R9 still idle", busy_o, 0);

        // R11 destination is the pointer, beats a core write
        start_i = 1'b1; mode_i = 1'b1; dst_i = 8'h07;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 8'h07; wr_data_i = 8'hEE;
        @(negedge clk);
        wr_en_i = 1'b0;
        w = rom_fn(12'hF11);
        rd_chk(8'h07, w[7:0], "R11 ptr from table");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule